// File: doc/BRIEF.md
# External Asynchronous Memory Bus Sequencer

This block turns single read and write requests from an on-chip requester into strobe sequences on an external asynchronous memory bus with one chip-select region. A request carries a 32-bit address, a size code (byte, halfword or word), right-justified write data and a direction. The address is compared with a programmable region base under a programmable ignore mask. A request that hits the region runs one or more bus beats, and a request that misses is refused at once with an error flag. The external port is configured as 8 or 16 bits wide. A request wider than the port is broken into consecutive beats, starting at the lowest address and sending the most significant data first.

Each beat walks through four named states with zero wait states and no address setup or hold. In **S0** the transfer-start strobe is driven. **S1** and **S2** are the strobe window, and read data is sampled at the clock edge that ends S2. **S3** terminates the transfer. The transitions are:
- IDLE→S0 on a request that hits the region.
- IDLE→IDLE on a miss, which returns done and error.
- S0→S1 and S1→S2 always.
- S2→S0 when more beats remain, so S3 is skipped.
- S2→S3 on the final beat.
- S3→IDLE, which raises done.

A non-final beat therefore lasts three clocks and the final beat lasts four. The acknowledge is produced inside the block.

Top module: `ebus_seq`

## Requirements
- R1: A request hits the region only when `cfg_valid` is 1 and every bit of `req_addr[31:16]` equals the matching bit of `cfg_base`, except bits whose `cfg_mask` bit is 1, which are ignored.
- R2: A request that misses is sampled at clock edge k. In the cycle after edge k, `rsp_done` and `rsp_err` are both 1 for one clock, and `bus_ts_n` and `bus_cs_n` stay 1 throughout.
- R3: A single-beat access holds `bus_cs_n` low for exactly 4 clocks (S0 to S3). `rsp_done` is 1, with `rsp_err` 0, in the clock after S3, which is the 5th cycle after the accepting edge.
- R4: The beat count is the request size divided by the beat width. The size code is 0 for byte, 1 for halfword and 2 for word. Beats are 8 bits wide on an 8-bit port (`cfg_port16`=0) or for byte requests, and 16 bits otherwise. A word on a 16-bit port therefore takes 2 beats, a word on an 8-bit port takes 4, and a halfword on an 8-bit port takes 2.
- R5: Every beat but the last skips S3 and lasts 3 clocks. An n-beat access holds `bus_cs_n` low for 3(n-1)+4 clocks without a break, and `rsp_done` arrives in the next clock.
- R6: Beat k drives `bus_addr` = request address + k·(beat width in bytes). Write data is sent most significant part first, so beat 0 of word 0xA1B2C3D4 on a 16-bit port carries 0xA1B2. The address does not change between S0 and the end of that beat.
- R7: In a write beat, `bus_we_n` is low in S1 and S2, and `bus_doe` is 1 from S1 to the end of the beat. `bus_oe_n` stays 1, and `bus_we_n` and `bus_oe_n` are never low together.
- R8: In a read beat, `bus_oe_n` is low from S1 to the end of the beat. The beat data is sampled at the end of S2. Beats are assembled with the first beat most significant, into a right-justified `rsp_rdata` with the upper bits zero, valid while `rsp_done` is 1.
- R9: Byte lanes are written as `bus_be_n`, active low, with bit 1 for data[15:8] and bit 0 for data[7:0]. They are driven from S1 to the end of the beat. On an 8-bit port the value is 2'b10. For a byte on a 16-bit port it is 2'b01 at an even address and 2'b10 at an odd address. Halfword beats use 2'b00. A byte beat places its byte on both halves of `bus_dout`.
- R10: A request presented while an access is in progress is ignored. It starts no beat, changes no address and produces no second done.
- R11: `bus_ts_n` is low for exactly one clock at the start of each beat. Within a split access, successive starts are 3 clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid | input | 1 | Region enable |
| cfg_base | input | 16 | Region base compared with address bits 31:16 |
| cfg_mask | input | 16 | 1 = ignore that base bit |
| cfg_port16 | input | 1 | 1 = 16-bit port, 0 = 8-bit port |
| req_valid | input | 1 | Request strobe, sampled only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | 32 | Request byte address |
| req_wdata | input | 32 | Right-justified write data |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_err | output | 1 | Region miss, valid with done |
| rsp_rdata | output | 32 | Right-justified read data |
| bus_ts_n | output | 1 | Transfer start, active low |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_we_n | output | 1 | Write enable, active low |
| bus_be_n | output | 2 | Byte lane enables, active low |
| bus_addr | output | 32 | Bus address |
| bus_dout | output | 16 | Write data to the bus |
| bus_doe | output | 1 | Write data drive enable |
| bus_din | input | 16 | Read data from the bus |

## Verification
Results are timed from the rising edge that samples the request. A miss reports done in the next cycle. An n-beat hit shows transfer starts in cycles 1, 4, 7 and so on after that edge, and done in cycle 3(n-1)+5. The bench drives each request at a falling edge, then samples the outputs on every following falling edge, and indexes each observation by its cycle number. Transfer-start cycles, chip-select length, the done cycle, per-beat addresses, data and lanes are each compared against those numbers. After done, a few idle cycles are also checked to confirm that no extra beat or done appears.

// File: rtl/ebus_pkg.sv
`timescale 1ns/1ps
package ebus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_S0   = 3'd1,
        ST_S1   = 3'd2,
        ST_S2   = 3'd3,
        ST_S3   = 3'd4
    } bus_state_t;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

endpackage

// File: rtl/ebus_region_match.sv
`timescale 1ns/1ps
module ebus_region_match #(
    parameter int ADDR_W  = 32,
    parameter int CMP_LSB = 16
) (
    input  logic [ADDR_W-1:0]         addr,
    input  logic [ADDR_W-CMP_LSB-1:0] base,
    input  logic [ADDR_W-CMP_LSB-1:0] mask,
    input  logic                      valid,
    output logic                      hit
);
    localparam int CMP_W = ADDR_W - CMP_LSB;

    logic [CMP_W-1:0] bit_ok;

    // One comparator per decoded address bit; a masked bit always agrees.
    for (genvar i = 0; i < CMP_W; i++) begin : g_cmp
        assign bit_ok[i] = mask[i] | (addr[CMP_LSB+i] == base[i]);
    end

    assign hit = valid & (&bit_ok);
endmodule

// File: rtl/ebus_beat_plan.sv
`timescale 1ns/1ps
module ebus_beat_plan
    import ebus_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]                 size,
    input  logic                       port16,
    output logic                       beat8,
    output logic [2:0]                 beats,
    output logic [1:0]                 step,
    output logic [$clog2(DATA_W)-1:0]  lj_shift
);
    localparam int SH_W = $clog2(DATA_W);

    always_comb begin
        beat8 = !port16 || (size == SZ_BYTE);
        step  = beat8 ? 2'd1 : 2'd2;
        unique case (size)
            SZ_BYTE: begin
                beats    = 3'd1;
                lj_shift = SH_W'(DATA_W - 8);
            end
            SZ_HALF: begin
                beats    = beat8 ? 3'd2 : 3'd1;
                lj_shift = SH_W'(DATA_W - 16);
            end
            default: begin
                beats    = beat8 ? 3'd4 : 3'd2;
                lj_shift = '0;
            end
        endcase
    end
endmodule

// File: rtl/ebus_lane_mux.sv
`timescale 1ns/1ps
module ebus_lane_mux #(
    parameter int BUS_W = 16
) (
    input  logic             beat8,
    input  logic             port16,
    input  logic             addr0,
    input  logic [BUS_W-1:0] wtop,
    input  logic [BUS_W-1:0] din,
    output logic [BUS_W-1:0] dout,
    output logic [1:0]       lane_be_n,
    output logic [BUS_W-1:0] beat_rd
);
    localparam int HB = BUS_W / 2;

    always_comb begin
        if (beat8) dout = {wtop[BUS_W-1 -: HB], wtop[BUS_W-1 -: HB]};
        else       dout = wtop;

        if (!port16)    lane_be_n = 2'b10;
        else if (beat8) lane_be_n = addr0 ? 2'b10 : 2'b01;
        else            lane_be_n = 2'b00;

        if (!port16)    beat_rd = {{HB{1'b0}}, din[HB-1:0]};
        else if (beat8) beat_rd = {{HB{1'b0}}, (addr0 ? din[HB-1:0] : din[BUS_W-1:HB])};
        else            beat_rd = din;
    end
endmodule

// File: rtl/ebus_seq.sv
`timescale 1ns/1ps
module ebus_seq
    import ebus_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int BUS_W   = 16,
    parameter int CMP_LSB = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_valid,
    input  logic [ADDR_W-CMP_LSB-1:0] cfg_base,
    input  logic [ADDR_W-CMP_LSB-1:0] cfg_mask,
    input  logic                      cfg_port16,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [1:0]                req_size,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [DATA_W-1:0]         req_wdata,
    output logic                      rsp_done,
    output logic                      rsp_err,
    output logic [DATA_W-1:0]         rsp_rdata,
    output logic                      bus_ts_n,
    output logic                      bus_cs_n,
    output logic                      bus_oe_n,
    output logic                      bus_we_n,
    output logic [1:0]                bus_be_n,
    output logic [ADDR_W-1:0]         bus_addr,
    output logic [BUS_W-1:0]          bus_dout,
    output logic                      bus_doe,
    input  logic [BUS_W-1:0]          bus_din
);
    localparam int SH_W = $clog2(DATA_W);
    localparam int BYTE = 8;

    bus_state_t state, state_nx;

    logic              hit;
    logic              pl_beat8;
    logic [2:0]        pl_beats;
    logic [1:0]        pl_step;
    logic [SH_W-1:0]   pl_shift;

    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] wsh;
    logic [DATA_W-1:0] acc;
    logic [2:0]        beats_left;
    logic [1:0]        cur_step;
    logic              cur_write;
    logic              cur_beat8;
    logic              cur_port16;
    logic              last_beat;

    logic [BUS_W-1:0]  lane_dout;
    logic [1:0]        lane_be_n;
    logic [BUS_W-1:0]  beat_rd;

    ebus_region_match #(.ADDR_W(ADDR_W), .CMP_LSB(CMP_LSB)) u_match (
        .addr  (req_addr),
        .base  (cfg_base),
        .mask  (cfg_mask),
        .valid (cfg_valid),
        .hit   (hit)
    );

    ebus_beat_plan #(.DATA_W(DATA_W)) u_plan (
        .size     (req_size),
        .port16   (cfg_port16),
        .beat8    (pl_beat8),
        .beats    (pl_beats),
        .step     (pl_step),
        .lj_shift (pl_shift)
    );

    ebus_lane_mux #(.BUS_W(BUS_W)) u_lane (
        .beat8     (cur_beat8),
        .port16    (cur_port16),
        .addr0     (cur_addr[0]),
        .wtop      (wsh[DATA_W-1 -: BUS_W]),
        .din       (bus_din),
        .dout      (lane_dout),
        .lane_be_n (lane_be_n),
        .beat_rd   (beat_rd)
    );

    assign last_beat = (beats_left <= 3'd1);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transition logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_valid && hit) state_nx = ST_S0;
            ST_S0:   state_nx = ST_S1;
            ST_S1:   state_nx = ST_S2;
            ST_S2:   state_nx = last_beat ? ST_S3 : ST_S0;
            ST_S3:   state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Access context, beat advance and read assembly
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr   <= '0;
            wsh        <= '0;
            acc        <= '0;
            beats_left <= '0;
            cur_step   <= '0;
            cur_write  <= 1'b0;
            cur_beat8  <= 1'b0;
            cur_port16 <= 1'b0;
            rsp_done   <= 1'b0;
            rsp_err    <= 1'b0;
            rsp_rdata  <= '0;
        end else begin
            rsp_done <= 1'b0;
            rsp_err  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (hit) begin
                            cur_addr   <= req_addr;
                            wsh        <= req_wdata << pl_shift;
                            acc        <= '0;
                            beats_left <= pl_beats;
                            cur_step   <= pl_step;
                            cur_write  <= req_write;
                            cur_beat8  <= pl_beat8;
                            cur_port16 <= cfg_port16;
                        end else begin
                            rsp_done <= 1'b1;
                            rsp_err  <= 1'b1;
                        end
                    end
                end
                ST_S2: begin
                    if (!cur_write) begin
                        if (cur_beat8) acc <= {acc[DATA_W-BYTE-1:0], beat_rd[BYTE-1:0]};
                        else           acc <= {acc[DATA_W-BUS_W-1:0], beat_rd};
                    end
                    if (!last_beat) begin
                        beats_left <= beats_left - 3'd1;
                        cur_addr   <= cur_addr + ADDR_W'(cur_step);
                        wsh        <= cur_beat8 ? (wsh << BYTE) : (wsh << BUS_W);
                    end
                end
                ST_S3: begin
                    rsp_done  <= 1'b1;
                    rsp_rdata <= cur_write ? '0 : acc;
                end
                default: ;
            endcase
        end
    end

    // Bus strobes decoded from the state
    always_comb begin
        bus_ts_n = 1'b1;
        bus_cs_n = 1'b0;
        bus_oe_n = 1'b1;
        bus_we_n = 1'b1;
        bus_doe  = 1'b0;
        bus_be_n = 2'b11;
        unique case (state)
            ST_IDLE: bus_cs_n = 1'b1;
            ST_S0:   bus_ts_n = 1'b0;
            ST_S1, ST_S2: begin
                bus_oe_n = cur_write;
                bus_we_n = !cur_write;
                bus_doe  = cur_write;
                bus_be_n = lane_be_n;
            end
            ST_S3: begin
                bus_oe_n = cur_write;
                bus_doe  = cur_write;
                bus_be_n = lane_be_n;
            end
            default: bus_cs_n = 1'b1;
        endcase
        bus_addr = cur_addr;
        bus_dout = lane_dout;
    end
endmodule

// File: rtl/ebus_seq_chk.sv
`timescale 1ns/1ps
module ebus_seq_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rsp_done,
    input logic              rsp_err,
    input logic              bus_ts_n,
    input logic              bus_cs_n,
    input logic              bus_oe_n,
    input logic              bus_we_n,
    input logic [ADDR_W-1:0] bus_addr
);
    p_ts_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ts_n |=> bus_ts_n);

    p_ts_in_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ts_n |-> !bus_cs_n);

    p_rw_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_we_n && !bus_oe_n));

    p_done_after_s3_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && !rsp_err) |-> (bus_cs_n && !$past(bus_cs_n)));

    p_miss_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_done && bus_cs_n && $past(bus_cs_n)));

    p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && bus_ts_n) |-> $stable(bus_addr));
endmodule

bind ebus_seq ebus_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rsp_done (rsp_done),
    .rsp_err  (rsp_err),
    .bus_ts_n (bus_ts_n),
    .bus_cs_n (bus_cs_n),
    .bus_oe_n (bus_oe_n),
    .bus_we_n (bus_we_n),
    .bus_addr (bus_addr)
);

// File: tb/ebus_seq_test.sv
`timescale 1ns/1ps
module ebus_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_valid = 1'b1;
    logic [15:0] cfg_base = 16'h1800;
    logic [15:0] cfg_mask = 16'h0007;
    logic        cfg_port16 = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_done, rsp_err;
    logic [31:0] rsp_rdata;
    logic        bus_ts_n, bus_cs_n, bus_oe_n, bus_we_n, bus_doe;
    logic [1:0]  bus_be_n;
    logic [31:0] bus_addr;
    logic [15:0] bus_dout, bus_din;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    ebus_seq uut (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_base(cfg_base),
        .cfg_mask(cfg_mask), .cfg_port16(cfg_port16), .req_valid(req_valid),
        .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .bus_ts_n(bus_ts_n), .bus_cs_n(bus_cs_n),
        .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n), .bus_be_n(bus_be_n),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din)
    );

    // Memory contents seen by the bus: one byte per address.
    function automatic logic [7:0] mb(input logic [31:0] a);
        return a[7:0] * 8'd3 + 8'h11;
    endfunction

    always_comb begin
        if (cfg_port16) bus_din = {mb({bus_addr[31:1], 1'b0}), mb({bus_addr[31:1], 1'b1})};
        else            bus_din = {8'h00, mb(bus_addr)};
    end

    function automatic logic [31:0] exp_read(input logic [31:0] a, input int nbytes);
        logic [31:0] e = '0;
        for (int i = 0; i < nbytes; i++) e = (e << 8) | 32'(mb(a + 32'(i)));
        return e;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Observations of one access, indexed by cycle after the accepting edge
    logic [31:0] o_addr[8];
    logic [15:0] o_dout[8];
    logic [1:0]  o_be[8];
    int          o_tscyc[8];
    int          o_ts, o_cs, o_we, o_oe, o_doe, o_done, o_done_cyc;
    logic        o_err;
    logic [31:0] o_rdata;

    task automatic do_access(input bit wr, input logic [1:0] sz, input logic [31:0] a,
                             input logic [31:0] wd, input int inject_at);
        o_ts = 0; o_cs = 0; o_we = 0; o_oe = 0; o_doe = 0; o_done = 0; o_done_cyc = 0;
        o_err = 1'b0; o_rdata = '0;
        for (int i = 0; i < 8; i++) begin
            o_addr[i] = '0; o_dout[i] = '0; o_be[i] = 2'b11; o_tscyc[i] = 0;
        end
        @(negedge clk);
        req_write = wr; req_size = sz; req_addr = a; req_wdata = wd; req_valid = 1'b1;
        for (int c = 1; c <= 40; c++) begin
            @(negedge clk);
            if (c == 1) req_valid = 1'b0;
            if (c == inject_at) begin
                req_valid = 1'b1; req_addr = a + 32'h100; req_write = !wr;
            end else if (c == inject_at + 1) begin
                req_valid = 1'b0;
            end
            if (!bus_ts_n) begin
                if (o_ts < 8) begin o_addr[o_ts] = bus_addr; o_tscyc[o_ts] = c; end
                o_ts++;
            end
            if (!bus_cs_n) o_cs++;
            if (!bus_we_n) begin
                o_we++;
                if (o_ts > 0 && o_ts <= 8) o_dout[o_ts-1] = bus_dout;
            end
            if (!bus_oe_n) o_oe++;
            if (bus_doe) o_doe++;
            if (bus_be_n != 2'b11 && o_ts > 0 && o_ts <= 8) o_be[o_ts-1] = bus_be_n;
            if (rsp_done) begin
                o_done++;
                if (o_done_cyc == 0) begin
                    o_done_cyc = c; o_err = rsp_err; o_rdata = rsp_rdata;
                end
            end
            if (o_done_cyc != 0 && c >= o_done_cyc + 3) break;
        end
    endtask

    task automatic t_reset;
        chk("R3 reset cs_n", 32'(bus_cs_n), 32'd1);
        chk("R11 reset ts_n", 32'(bus_ts_n), 32'd1);
        chk("R7 reset we_n/oe_n", {30'd0, bus_we_n, bus_oe_n}, 32'd3);
        chk("R9 reset be_n", 32'(bus_be_n), 32'd3);
        chk("R2 reset done", 32'(rsp_done), 32'd0);
    endtask

    task automatic t_region;
        cfg_valid = 1'b1; cfg_base = 16'h1800; cfg_mask = 16'h0007; cfg_port16 = 1'b1;
        do_access(1'b0, 2'd1, 32'h2000_0000, '0, 0);
        chk("R2 miss done cycle", 32'(o_done_cyc), 32'd1);
        chk("R2 miss err", 32'(o_err), 32'd1);
        chk("R2 miss no bus", 32'(o_ts + o_cs), 32'd0);
        do_access(1'b0, 2'd1, 32'h1805_0010, '0, 0);
        chk("R1 masked bits hit", 32'(o_err), 32'd0);
        chk("R1 masked bits beats", 32'(o_ts), 32'd1);
        do_access(1'b0, 2'd1, 32'h1808_0000, '0, 0);
        chk("R1 unmasked bit miss", 32'(o_err), 32'd1);
        cfg_valid = 1'b0;
        do_access(1'b0, 2'd1, 32'h1800_0000, '0, 0);
        chk("R1 invalid region miss", 32'(o_err), 32'd1);
        chk("R2 invalid region no cs", 32'(o_cs), 32'd0);
        cfg_valid = 1'b1;
    endtask

    task automatic t_single_write;
        cfg_port16 = 1'b1;
        do_access(1'b1, 2'd1, 32'h1800_0040, 32'h0000_BEEF, 0);
        chk("R3 single cs clocks", 32'(o_cs), 32'd4);
        chk("R3 single done cycle", 32'(o_done_cyc), 32'd5);
        chk("R3 single err", 32'(o_err), 32'd0);
        chk("R3 single done once", 32'(o_done), 32'd1);
        chk("R11 single ts cycle", 32'(o_tscyc[0]), 32'd1);
        chk("R7 we clocks", 32'(o_we), 32'd2);
        chk("R7 doe clocks", 32'(o_doe), 32'd3);
        chk("R7 oe stays high", 32'(o_oe), 32'd0);
        chk("R6 single addr", o_addr[0], 32'h1800_0040);
        chk("R6 single data", 32'(o_dout[0]), 32'h0000_BEEF);
        chk("R9 half lanes", 32'(o_be[0]), 32'd0);
    endtask

    task automatic t_word_write16;
        cfg_port16 = 1'b1;
        do_access(1'b1, 2'd2, 32'h1800_0100, 32'hA1B2_C3D4, 0);
        chk("R4 word/16 beats", 32'(o_ts), 32'd2);
        chk("R5 word/16 cs clocks", 32'(o_cs), 32'd7);
        chk("R5 word/16 done cycle", 32'(o_done_cyc), 32'd8);
        chk("R11 word/16 second ts", 32'(o_tscyc[1]), 32'd4);
        chk("R6 beat0 addr", o_addr[0], 32'h1800_0100);
        chk("R6 beat1 addr", o_addr[1], 32'h1800_0102);
        chk("R6 beat0 data", 32'(o_dout[0]), 32'h0000_A1B2);
        chk("R6 beat1 data", 32'(o_dout[1]), 32'h0000_C3D4);
        chk("R7 split we clocks", 32'(o_we), 32'd4);
        chk("R7 split doe clocks", 32'(o_doe), 32'd5);
    endtask

    task automatic t_word_read8;
        cfg_port16 = 1'b0;
        do_access(1'b0, 2'd2, 32'h1800_0200, '0, 0);
        chk("R4 word/8 beats", 32'(o_ts), 32'd4);
        chk("R5 word/8 cs clocks", 32'(o_cs), 32'd13);
        chk("R5 word/8 done cycle", 32'(o_done_cyc), 32'd14);
        chk("R11 word/8 fourth ts", 32'(o_tscyc[3]), 32'd10);
        chk("R6 word/8 beat3 addr", o_addr[3], 32'h1800_0203);
        chk("R8 word/8 oe clocks", 32'(o_oe), 32'd9);
        chk("R8 word/8 rdata", o_rdata, exp_read(32'h1800_0200, 4));
        chk("R9 8-bit port lanes", 32'(o_be[2]), 32'd2);
        chk("R7 read no we", 32'(o_we), 32'd0);
        cfg_port16 = 1'b1;
    endtask

    task automatic t_half_write8;
        cfg_port16 = 1'b0;
        do_access(1'b1, 2'd1, 32'h1800_0300, 32'h0000_5A6B, 0);
        chk("R4 half/8 beats", 32'(o_ts), 32'd2);
        chk("R5 half/8 cs clocks", 32'(o_cs), 32'd7);
        chk("R6 half/8 beat0 byte", 32'(o_dout[0]), 32'h0000_5A5A);
        chk("R6 half/8 beat1 byte", 32'(o_dout[1]), 32'h0000_6B6B);
        chk("R6 half/8 beat1 addr", o_addr[1], 32'h1800_0301);
        cfg_port16 = 1'b1;
    endtask

    task automatic t_byte_read16;
        cfg_port16 = 1'b1;
        do_access(1'b0, 2'd0, 32'h1800_0401, '0, 0);
        chk("R9 odd byte lanes", 32'(o_be[0]), 32'd2);
        chk("R8 odd byte rdata", o_rdata, exp_read(32'h1800_0401, 1));
        chk("R3 byte done cycle", 32'(o_done_cyc), 32'd5);
        do_access(1'b0, 2'd0, 32'h1800_0402, '0, 0);
        chk("R9 even byte lanes", 32'(o_be[0]), 32'd1);
        chk("R8 even byte rdata", o_rdata, exp_read(32'h1800_0402, 1));
        do_access(1'b0, 2'd1, 32'h1800_0404, '0, 0);
        chk("R8 half rdata", o_rdata, exp_read(32'h1800_0404, 2));
        do_access(1'b0, 2'd2, 32'h1800_0408, '0, 0);
        chk("R8 word/16 rdata", o_rdata, exp_read(32'h1800_0408, 4));
    endtask

    task automatic t_busy_ignore;
        cfg_port16 = 1'b1;
        do_access(1'b1, 2'd2, 32'h1800_0500, 32'h1122_3344, 3);
        chk("R10 beats unchanged", 32'(o_ts), 32'd2);
        chk("R10 second beat addr", o_addr[1], 32'h1800_0502);
        chk("R10 single done", 32'(o_done), 32'd1);
        chk("R10 done cycle", 32'(o_done_cyc), 32'd8);
        chk("R10 data kept", 32'(o_dout[1]), 32'h0000_3344);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_region();
        t_single_write();
        t_word_write16();
        t_word_read8();
        t_half_write8();
        t_byte_read16();
        t_busy_ignore();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule